// File: doc/BRIEF.md
# Serial Flash Status and Configuration Register

This block keeps the 16-bit status and configuration word of a quad-capable serial NOR flash model. A command decoder in front of it presents one decoded opcode per strobe. The block acts on five opcodes: write-enable, write-disable, write-register, suspend and resume. It also samples three live inputs: erase in progress, program in progress and high-performance mode active. A power-cycle pulse reproduces what a supply drop does to the volatile and partly volatile fields.

The word mixes several kinds of bit:

- Plain read/write configuration: the protection complement, quad enable, the protection-mode pair and drive strength.
- One-time-programmable security locks.
- Suspend flags that only opcodes or a power cycle can change.
- Live read-only flags.

Field outputs let the pin multiplexer and the security-region logic use the values directly, without decoding the word.

Top module: `flash_status_unit`

Status word layout:

| Bit(s) | Field |
|---|---|
| 15 | erase suspended |
| 14 | protection complement |
| 13:11 | lock bits (bit 11 → lock_flags[0]) |
| 10 | program suspended |
| 9 | quad enable |
| 8:7 | protection mode (bit 8 high) |
| 6:5 | drive strength |
| 4 | high-performance flag |
| 3:2 | read as 0 |
| 1 | write-enable latch |
| 0 | busy (erase or program in progress) |

Opcodes: 06h write-enable, 04h write-disable, 01h write-register, 75h suspend, 7Ah resume.

## Requirements
- R1: An asynchronous reset loads status 0x0020: every field is 0 except drive strength, which is 01.
- R2: Opcode 06h sets the write-enable latch (bit 1) and 04h clears it. Opcode 01h has an effect only while the latch is set, and it clears the latch. With the latch clear, 01h leaves the word unchanged.
- R3: An effective write-register loads data bits 14, 9, 8:7 and 6:5 into the protection complement, quad enable, protection mode and drive strength. Drive code 00 means 100%, 01 means 75%, 10 means 50% and 11 means 25%. Data on bits 15, 10, 4 and 3:0 is ignored.
- R4: Each lock bit (13:11) takes the OR of its old value and the written data bit. A lock bit can be set on its own, and once set it clears only on reset.
- R5: Opcode 75h sets bit 15 if an erase is in progress. Otherwise it sets bit 10 if a program is in progress. With neither in progress, the word is unchanged.
- R6: Opcode 7Ah clears both suspend flags.
- R7: A power-cycle pulse clears both suspend flags and the write-enable latch. It changes protection mode 10 to 00 and keeps any other value, and it keeps every other field. A command in the same cycle is ignored.
- R8: Bit 4 follows the high-performance input, and bit 0 is the OR of the two in-progress inputs, both in the same cycle.
- R9: quad_en, prot_cmp, lock_flags and drive_str always equal bits 9, 14, 13:11 and 6:5 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 8 | Opcode of the command |
| wr_data | input | 16 | Data for the write-register command |
| erase_busy | input | 1 | Erase in progress |
| program_busy | input | 1 | Program in progress |
| hpm_active | input | 1 | High-performance mode active |
| power_cycle | input | 1 | Power-down/power-up event pulse |
| status_word | output | 16 | Full status word |
| quad_en | output | 1 | 1: extra pins are IO2/IO3; 0: write-protect and hold |
| lock_flags | output | 3 | Security-region lock bits |
| prot_cmp | output | 1 | Protection complement bit |
| drive_str | output | 2 | Output drive-strength code |

## Verification
Every stored field is visible in the status word one clock after the command that changes it. A wrong latch, lock or suspend state therefore shows at the next sample, or at the latest on the next write-register command, which either takes effect or does not. A lock bit that falls, or a protection-mode value that does not revert after a power pulse, stays wrong and visible until reset. The field outputs and the word are compared every cycle, so a split between them shows at once.

// File: rtl/flash_status_unit.sv
module flash_status_unit #(
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRDI = 8'h04,
  parameter logic [7:0] OP_WRSR = 8'h01,
  parameter logic [7:0] OP_SUSP = 8'h75,
  parameter logic [7:0] OP_RESM = 8'h7A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic [15:0] wr_data,
  input  logic        erase_busy,
  input  logic        program_busy,
  input  logic        hpm_active,
  input  logic        power_cycle,
  output logic [15:0] status_word,
  output logic        quad_en,
  output logic [2:0]  lock_flags,
  output logic        prot_cmp,
  output logic [1:0]  drive_str
);

  logic       sus_erase, sus_prog, cmp_q, qe_q, wel_q;
  logic [2:0] lock_q;
  logic [1:0] pmode_q, drv_q;

  wire unused_wdata = ^{wr_data[15], wr_data[10], wr_data[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sus_erase <= 1'b0;
      sus_prog  <= 1'b0;
      cmp_q     <= 1'b0;
      qe_q      <= 1'b0;
      wel_q     <= 1'b0;
      lock_q    <= 3'b000;
      pmode_q   <= 2'b00;
      drv_q     <= 2'b01;
    end else if (power_cycle) begin
      sus_erase <= 1'b0;
      sus_prog  <= 1'b0;
      wel_q     <= 1'b0;
      if (pmode_q == 2'b10) pmode_q <= 2'b00;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_WREN: wel_q <= 1'b1;
        OP_WRDI: wel_q <= 1'b0;
        OP_WRSR: if (wel_q) begin
          cmp_q   <= wr_data[14];
          lock_q  <= lock_q | wr_data[13:11];
          qe_q    <= wr_data[9];
          pmode_q <= wr_data[8:7];
          drv_q   <= wr_data[6:5];
          wel_q   <= 1'b0;
        end
        OP_SUSP: begin
          if (erase_busy)        sus_erase <= 1'b1;
          else if (program_busy) sus_prog  <= 1'b1;
        end
        OP_RESM: begin
          sus_erase <= 1'b0;
          sus_prog  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign status_word = {sus_erase, cmp_q, lock_q, sus_prog, qe_q, pmode_q, drv_q,
                        hpm_active, 2'b00, wel_q, erase_busy | program_busy};
  assign quad_en    = qe_q;
  assign lock_flags = lock_q;
  assign prot_cmp   = cmp_q;
  assign drive_str  = drv_q;

endmodule

// File: rtl/flash_status_unit_chk.sv
module flash_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [7:0]  cmd_op,
  input logic        erase_busy,
  input logic        program_busy,
  input logic        hpm_active,
  input logic        power_cycle,
  input logic [15:0] status_word,
  input logic        quad_en,
  input logic [2:0]  lock_flags,
  input logic        prot_cmp,
  input logic [1:0]  drive_str
);

  assert_wrsr_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h01 && !status_word[1] && !power_cycle)
      |=> $stable(status_word[15:5]));

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_flags & $past(lock_flags)) == $past(lock_flags)));

  assert_susp_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h75 && !erase_busy && !program_busy && !power_cycle)
      |=> $stable(status_word[15:5]));

  assert_resume_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h7A && !power_cycle)
      |=> (!status_word[15] && !status_word[10]));

  assert_power_revert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    power_cycle |=> (!status_word[15] && !status_word[10] && !status_word[1]
                     && status_word[8:7] != 2'b10));

  always_comb begin
    if (rst_n) begin
      assert_live_flags_R8: assert (status_word[4] == hpm_active &&
                                    status_word[0] == (erase_busy | program_busy));
      assert_field_ports_R9: assert (quad_en == status_word[9] && prot_cmp == status_word[14] &&
                                     lock_flags == status_word[13:11] && drive_str == status_word[6:5]);
    end
  end

endmodule

bind flash_status_unit flash_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .erase_busy(erase_busy), .program_busy(program_busy), .hpm_active(hpm_active),
  .power_cycle(power_cycle), .status_word(status_word), .quad_en(quad_en),
  .lock_flags(lock_flags), .prot_cmp(prot_cmp), .drive_str(drive_str)
);

// File: tb/flash_status_unit_tb.sv
module flash_status_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] wr_data = 16'h0000;
  logic        erase_busy = 1'b0, program_busy = 1'b0, hpm_active = 1'b0, power_cycle = 1'b0;
  logic [15:0] status_word;
  logic        quad_en, prot_cmp;
  logic [2:0]  lock_flags;
  logic [1:0]  drive_str;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  flash_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wr_data(wr_data),
    .erase_busy(erase_busy), .program_busy(program_busy), .hpm_active(hpm_active),
    .power_cycle(power_cycle), .status_word(status_word), .quad_en(quad_en),
    .lock_flags(lock_flags), .prot_cmp(prot_cmp), .drive_str(drive_str)
  );

  // {power_cycle, cmd_valid, op, data, erase_busy, program_busy, expected status}
  localparam int NVEC = 18;
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h01, 16'hFFFF, 1'b0, 1'b0, 16'h0020}, // R2 write ignored without latch
    {1'b0, 1'b1, 8'h06, 16'h0000, 1'b0, 1'b0, 16'h0022}, // R2 latch set
    {1'b0, 1'b1, 8'h01, 16'hFFFF, 1'b0, 1'b0, 16'h7BE0}, // R3 R4 full write, latch clears
    {1'b0, 1'b1, 8'h06, 16'h0000, 1'b0, 1'b0, 16'h7BE2},
    {1'b0, 1'b1, 8'h01, 16'h0000, 1'b0, 1'b0, 16'h3800}, // R4 locks hold
    {1'b0, 1'b1, 8'h06, 16'h0000, 1'b0, 1'b0, 16'h3802},
    {1'b0, 1'b1, 8'h01, 16'h0140, 1'b0, 1'b0, 16'h3940}, // R3 pmode 10, drive 10
    {1'b0, 1'b1, 8'h75, 16'h0000, 1'b1, 1'b0, 16'hB941}, // R5 erase suspend
    {1'b0, 1'b1, 8'h75, 16'h0000, 1'b0, 1'b1, 16'hBD41}, // R5 program suspend
    {1'b0, 1'b1, 8'h7A, 16'h0000, 1'b0, 1'b0, 16'h3940}, // R6 resume
    {1'b0, 1'b1, 8'h75, 16'h0000, 1'b0, 1'b0, 16'h3940}, // R5 idle suspend ignored
    {1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h3840}, // R7 pmode 10 reverts
    {1'b1, 1'b1, 8'h06, 16'h0000, 1'b0, 1'b0, 16'h3840}, // R7 command ignored
    {1'b0, 1'b1, 8'h06, 16'h0000, 1'b0, 1'b0, 16'h3842},
    {1'b0, 1'b1, 8'h01, 16'h0180, 1'b0, 1'b0, 16'h3980}, // R3 pmode 11
    {1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h3980}, // R7 pmode 11 kept
    {1'b0, 1'b1, 8'h75, 16'h0000, 1'b1, 1'b0, 16'hB981}, // R5
    {1'b1, 1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h3980}  // R7 suspend cleared
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic pc, input logic v, input logic [7:0] op, input logic [15:0] d,
                      input logic eb, input logic pb);
    @(negedge clk);
    power_cycle = pc; cmd_valid = v; cmd_op = op; wr_data = d; erase_busy = eb; program_busy = pb;
    @(negedge clk);
    power_cycle = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    step(1'b0, 1'b1, 8'h06, 16'h0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 8'h01, d, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #20;
    check("R1", status_word, 16'h0020);
    check("R9", {13'h0, drive_str, quad_en}, {13'h0, 2'b01, 1'b0});
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][43], VEC[i][42], VEC[i][41:34], VEC[i][33:18], VEC[i][17], VEC[i][16]);
      check($sformatf("R2-R7 vec%0d", i), status_word, VEC[i][15:0]);
      erase_busy = 1'b0; program_busy = 1'b0;
    end
    check("R9", {lock_flags, prot_cmp, quad_en, drive_str, 9'h0},
          {status_word[13:11], status_word[14], status_word[9], status_word[6:5], 9'h0});

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 locks cleared by reset", status_word, 16'h0020);
    rst_n = 1'b1;

    wr(16'h1000);
    check("R4 single lock", {13'h0, lock_flags}, 16'h0002);
    wr(16'h0800);
    check("R4 second lock", {13'h0, lock_flags}, 16'h0003);
    wr(16'h8000 | 16'h0400 | 16'h0013);
    check("R3 read-only data ignored", status_word, 16'h1800);

    step(1'b0, 1'b1, 8'h06, 16'h0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 8'h04, 16'h0, 1'b0, 1'b0);
    check("R2 disable clears latch", status_word, 16'h1800);
    step(1'b0, 1'b1, 8'h01, 16'h0200, 1'b0, 1'b0);
    check("R2 write after disable ignored", {15'h0, quad_en}, 16'h0000);

    wr(16'h4200);
    check("R9 quad_en and prot_cmp", {14'h0, prot_cmp, quad_en}, 16'h0003);

    step(1'b0, 1'b1, 8'h75, 16'h0, 1'b1, 1'b1);
    check("R5 erase has priority", {status_word[15], status_word[10]}, 16'h0002);
    erase_busy = 1'b0; program_busy = 1'b0;

    @(negedge clk); hpm_active = 1'b1;
    #1;
    check("R8 high-performance flag", {15'h0, status_word[4]}, 16'h0001);
    hpm_active = 1'b0; program_busy = 1'b1;
    #1;
    check("R8 busy flag", {status_word[4], status_word[0]}, 16'h0001);
    program_busy = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule